// File: doc/BRIEF.md
# Read-After-Write Stall Controller

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) may proceed. The pipeline has no result forwarding. Operands are read from the register file in decode, and results are written only in write-back. An instruction in decode can therefore ask for a register that an older instruction, still in flight, has not yet written.

The controller compares both decode-stage source register numbers against the destination register numbers held in the three later pipeline registers: decode/execute, execute/memory and memory/write-back. A destination counts only when the write enable of its stage is set. Register zero never counts.

On any match, three things happen in the same cycle. The program counter is frozen, the fetch/decode pipeline register is frozen, and a bubble select tells the decode/execute register to load a no-op with its memory-write and register-write flags cleared. The dependent instruction waits in decode until its producer has left all three compared stages. The block is purely combinational and has no clock of its own.

Top module: `hzd_stall_ctrl`

## Requirements
- R1: When no enabled later-stage destination equals a nonzero source, the outputs in the same cycle are pc_wen_o=1, fd_wen_o=1 and bubble_o=0.
- R2: When src_a_i is nonzero and equals the destination of any one of the three later stages whose write enable is 1, the block stalls. A stall means pc_wen_o=0, fd_wen_o=0 and bubble_o=1.
- R3: When src_b_i is nonzero and equals the destination of any one of the three later stages whose write enable is 1, the block stalls in the same way as in R2.
- R4: A source field of value 0 never causes a stall, even when an enabled stage holds destination 0.
- R5: A stage whose write enable is 0 never causes a stall, whatever its destination field holds. Bubbles carry write enable 0.
- R6: The three outputs always agree: pc_wen_o equals fd_wen_o, and bubble_o is their inverse.
- R7: When the bench pipeline model advances under the block's control, a consumer that directly follows its producer stalls 3 cycles. With one unrelated instruction between them it stalls 2 cycles, with two it stalls 1 cycle, and with three it does not stall.
- R8: The register field width is the parameter REG_W, with a default of 3 for an eight-register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | REG_W | First source register number of the decode-stage instruction |
| src_b_i | input | REG_W | Second source register number of the decode-stage instruction |
| ex_rd_i | input | REG_W | Destination register held in decode/execute |
| ex_wen_i | input | 1 | Register write enable held in decode/execute |
| mem_rd_i | input | REG_W | Destination register held in execute/memory |
| mem_wen_i | input | 1 | Register write enable held in execute/memory |
| wb_rd_i | input | REG_W | Destination register held in memory/write-back |
| wb_wen_i | input | 1 | Register write enable held in memory/write-back |
| pc_wen_o | output | 1 | Program counter update enable |
| fd_wen_o | output | 1 | Fetch/decode pipeline register load enable |
| bubble_o | output | 1 | Selects a no-op for the decode/execute register |

## Verification
The bench builds the block with its default REG_W of 3, so all eight register numbers can be reached. This lets directed cases cover register zero, the highest register and matches in each of the three stages for either operand. A small behavioural pipeline in the bench is advanced by the block's own outputs. This exposes the stall lengths that follow from producer distances of zero to three instructions, including an operand pair that depends on two producers. The per-cycle outputs are compared with an independent reference on every clock.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Order of the later pipeline stages compared against decode sources.
  typedef enum logic [1:0] {
    STG_EX  = 2'd0,
    STG_MEM = 2'd1,
    STG_WB  = 2'd2
  } stage_e;

  localparam int NUM_LATER = 3;
  localparam int NUM_SRC   = 2;
endpackage

// File: rtl/hzd_dest_match.sv
module hzd_dest_match #(
  parameter int REG_W = 3
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic             wen_i,
  output logic             hit_o
);
  logic src_live;

  always_comb begin
    src_live = (src_i != '0);
    hit_o    = src_live && wen_i && (src_i == rd_i);
  end

  // R4 / R5: a hit needs a nonzero source and an enabled writer
  always_comb begin
    if (hit_o) begin
      p_hit_needs_source_r4: assert (src_i != '0);
      p_hit_needs_wen_r5:    assert (wen_i);
    end
  end
endmodule

// File: rtl/hzd_operand_scan.sv
module hzd_operand_scan #(
  parameter int REG_W = 3,
  parameter int NSTG  = 3
) (
  input  logic [REG_W-1:0]      src_i,
  input  logic [NSTG-1:0][REG_W-1:0] rd_i,
  input  logic [NSTG-1:0]       wen_i,
  output logic                  busy_o
);
  logic [NSTG-1:0] stage_hit;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    hzd_dest_match #(.REG_W(REG_W)) u_match (
      .src_i (src_i),
      .rd_i  (rd_i[s]),
      .wen_i (wen_i[s]),
      .hit_o (stage_hit[s])
    );
  end

  always_comb busy_o = |stage_hit;

  // R5: no enabled stage means the operand is never busy
  always_comb begin
    if (wen_i == '0) p_idle_stages_r5: assert (!busy_o);
  end
endmodule

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic [REG_W-1:0] src_a_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_wen_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wen_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_wen_i,
  output logic             pc_wen_o,
  output logic             fd_wen_o,
  output logic             bubble_o
);
  logic [NUM_LATER-1:0][REG_W-1:0] rd_vec;
  logic [NUM_LATER-1:0]            wen_vec;
  logic [NUM_SRC-1:0][REG_W-1:0]   src_vec;
  logic [NUM_SRC-1:0]              src_busy;
  logic                            stall;

  always_comb begin
    rd_vec[STG_EX]   = ex_rd_i;
    rd_vec[STG_MEM]  = mem_rd_i;
    rd_vec[STG_WB]   = wb_rd_i;
    wen_vec[STG_EX]  = ex_wen_i;
    wen_vec[STG_MEM] = mem_wen_i;
    wen_vec[STG_WB]  = wb_wen_i;
    src_vec[0]       = src_a_i;
    src_vec[1]       = src_b_i;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    hzd_operand_scan #(.REG_W(REG_W), .NSTG(NUM_LATER)) u_scan (
      .src_i  (src_vec[k]),
      .rd_i   (rd_vec),
      .wen_i  (wen_vec),
      .busy_o (src_busy[k])
    );
  end

  always_comb begin
    stall    = |src_busy;
    pc_wen_o = !stall;
    fd_wen_o = !stall;
    bubble_o = stall;
  end

  always_comb begin
    // R4: two zero sources never hold the pipeline
    if (src_a_i == '0 && src_b_i == '0)
      p_zero_sources_r4: assert (pc_wen_o && !bubble_o);
    // R2: a live source A match in the execute stage forces a stall
    if (src_a_i != '0 && ex_wen_i && src_a_i == ex_rd_i)
      p_src_a_ex_r2: assert (bubble_o && !pc_wen_o);
    // R3: a live source B match in the write-back stage forces a stall
    if (src_b_i != '0 && wb_wen_i && src_b_i == wb_rd_i)
      p_src_b_wb_r3: assert (bubble_o && !fd_wen_o);
    // R1: no enabled writer at all leaves the pipeline free
    if (!ex_wen_i && !mem_wen_i && !wb_wen_i)
      p_no_writer_r1: assert (pc_wen_o && fd_wen_o && !bubble_o);
  end
endmodule

// File: tb/hzd_stall_ctrl_test.sv
module hzd_stall_ctrl_test;
  localparam int RW = 3;

  typedef struct packed {
    logic [RW-1:0] rd;
    logic [RW-1:0] ra;
    logic [RW-1:0] rb;
    logic          we;
  } ins_t;

  localparam ins_t BUB = '0;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [RW-1:0] src_a, src_b, ex_rd, mem_rd, wb_rd;
  logic ex_wen, mem_wen, wb_wen;
  logic pc_wen, fd_wen, bubble;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  hzd_stall_ctrl #(.REG_W(RW)) uut (
    .src_a_i(src_a), .src_b_i(src_b),
    .ex_rd_i(ex_rd), .ex_wen_i(ex_wen),
    .mem_rd_i(mem_rd), .mem_wen_i(mem_wen),
    .wb_rd_i(wb_rd), .wb_wen_i(wb_wen),
    .pc_wen_o(pc_wen), .fd_wen_o(fd_wen), .bubble_o(bubble)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: stall if any live source equals an enabled destination.
  function automatic bit ref_stall(input ins_t d, input ins_t e, input ins_t m, input ins_t w);
    ins_t later[3];
    logic [RW-1:0] srcs[2];
    bit s = 0;
    later[0] = e; later[1] = m; later[2] = w;
    srcs[0] = d.ra; srcs[1] = d.rb;
    foreach (srcs[i])
      foreach (later[j])
        if (srcs[i] != 0 && later[j].we && later[j].rd == srcs[i]) s = 1;
    return s;
  endfunction

  task automatic drive(input ins_t d, input ins_t e, input ins_t m, input ins_t w);
    src_a = d.ra; src_b = d.rb;
    ex_rd = e.rd; ex_wen = e.we;
    mem_rd = m.rd; mem_wen = m.we;
    wb_rd = w.rd; wb_wen = w.we;
  endtask

  task automatic cmp_outputs(input bit exp_st, input string req, input string what);
    chk(pc_wen == !exp_st, req, {what, " pc_wen"}, pc_wen, !exp_st);
    chk(fd_wen == !exp_st, req, {what, " fd_wen"}, fd_wen, !exp_st);
    chk(bubble == exp_st, req, {what, " bubble"}, bubble, exp_st);
    chk((pc_wen == fd_wen) && (bubble == !pc_wen), "R6", {what, " coherence"},
        {pc_wen, fd_wen, bubble}, {!exp_st, !exp_st, exp_st});
  endtask

  task automatic direct(input ins_t d, input ins_t e, input ins_t m, input ins_t w,
                        input bit exp_st, input string req, input string what);
    drive(d, e, m, w);
    @(negedge clk);
    chk(ref_stall(d, e, m, w) == exp_st, req, {what, " reference"}, ref_stall(d, e, m, w), exp_st);
    cmp_outputs(exp_st, req, what);
  endtask

  function automatic ins_t mk(input int rd, input int ra, input int rb, input bit we);
    ins_t t;
    t.rd = RW'(rd); t.ra = RW'(ra); t.rb = RW'(rb); t.we = we;
    return t;
  endfunction

  ins_t prog[8];

  // R7: run a program through the bench pipeline steered by the block's outputs.
  task automatic run_prog(input int n, input int exp_stalls, input string what);
    ins_t fd = BUB, dx = BUB, xm = BUB, mw = BUB;
    int pc = 0;
    int stalls = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      bit e;
      drive(fd, dx, xm, mw);
      @(negedge clk);
      e = ref_stall(fd, dx, xm, mw);
      cmp_outputs(e, "R2 R3 R7", what);
      if (e) stalls++;
      @(posedge clk);
      mw = xm;
      xm = dx;
      if (e) dx = BUB;
      else begin
        dx = fd;
        fd = (pc < n) ? prog[pc] : BUB;
        pc++;
      end
    end
    chk(stalls == exp_stalls, "R7", {what, " stall cycles"}, stalls, exp_stalls);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    ins_t filler;
    filler = mk(5, 0, 0, 1);
    // Reset-like idle state: all bubbles.
    direct(BUB, BUB, BUB, BUB, 0, "R1", "idle");
    direct(mk(1, 2, 3, 1), mk(4, 0, 0, 1), mk(5, 0, 0, 1), mk(6, 0, 0, 1), 0, "R1", "no match");
    direct(mk(1, 3, 0, 1), mk(3, 0, 0, 1), BUB, BUB, 1, "R2", "A vs ex");
    direct(mk(1, 7, 0, 1), BUB, mk(7, 0, 0, 1), BUB, 1, "R2", "A vs mem r7");
    direct(mk(1, 2, 0, 1), BUB, BUB, mk(2, 0, 0, 1), 1, "R2", "A vs wb");
    direct(mk(1, 0, 4, 1), mk(4, 0, 0, 1), BUB, BUB, 1, "R3", "B vs ex");
    direct(mk(1, 0, 6, 1), BUB, mk(6, 0, 0, 1), BUB, 1, "R3", "B vs mem");
    direct(mk(1, 0, 1, 1), BUB, BUB, mk(1, 0, 0, 1), 1, "R3", "B vs wb");
    direct(mk(1, 0, 0, 1), mk(0, 0, 0, 1), mk(0, 0, 0, 1), mk(0, 0, 0, 1), 0, "R4", "zero src");
    direct(mk(1, 3, 3, 1), mk(3, 0, 0, 0), mk(3, 0, 0, 0), mk(3, 0, 0, 0), 0, "R5", "wen low");
    direct(mk(1, 3, 0, 1), mk(3, 0, 0, 0), mk(3, 0, 0, 1), BUB, 1, "R5", "one wen high");
    direct(mk(1, 7, 7, 1), mk(7, 0, 0, 1), mk(7, 0, 0, 1), mk(7, 0, 0, 1), 1, "R8", "max reg");

    prog[0] = mk(3, 1, 2, 1); prog[1] = mk(5, 3, 0, 1);
    run_prog(2, 3, "distance 0");
    prog[0] = mk(3, 1, 2, 1); prog[1] = filler; prog[2] = mk(6, 0, 3, 1);
    run_prog(3, 2, "distance 1");
    prog[0] = mk(3, 1, 2, 1); prog[1] = filler; prog[2] = filler; prog[3] = mk(6, 3, 0, 1);
    run_prog(4, 1, "distance 2");
    prog[0] = mk(3, 1, 2, 1); prog[1] = filler; prog[2] = filler; prog[3] = filler;
    prog[4] = mk(6, 3, 3, 1);
    run_prog(5, 0, "distance 3");
    prog[0] = mk(0, 1, 2, 1); prog[1] = mk(6, 0, 0, 1);
    run_prog(2, 0, "R4 write r0");
    prog[0] = mk(3, 1, 2, 0); prog[1] = mk(6, 3, 0, 1);
    run_prog(2, 0, "R5 store");
    prog[0] = mk(1, 0, 0, 1); prog[1] = mk(2, 0, 0, 1); prog[2] = mk(6, 1, 2, 1);
    run_prog(3, 3, "two producers");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule